// File: doc/BRIEF.md
# Prefetch Landing Buffer

This block sits on the host side, between the last-level cache controller and the memory link. It holds whole cache lines that a memory expander has pushed toward the host ahead of demand. Every read that misses the last-level cache is offered to the buffer first. When the line is held locally it is returned one cycle later and no traffic goes downstream. The device is still told about the hit through a separate hint output, so it keeps seeing when requests happen. When the line is not held, the block issues a downstream read that carries the requesting program counter along with the line address.

Lines arrive in two phases. First a snoop header with a data-push opcode arrives, and it carries no data. Then the line follows as separate payload beats. The block arms on the header and collects the beats. It installs the complete line only when the last beat arrives. The store is fully associative. A push for an address already held replaces that entry in place. Otherwise the oldest install is evicted once the store is full.

Top module: `lpb_landing_buf`

## Requirements
- R1: After a synchronous reset no entry is valid. `rsp_valid_o`, `dn_valid_o` and `hint_valid_o` are low and `snp_ready_o` is high.
- R2: A lookup (`lk_valid_i`) whose line address is held produces, on the next cycle, `rsp_valid_o` and `rsp_hit_o` high with the stored line on `rsp_data_o`. On that cycle `dn_valid_o` is low.
- R3: A lookup whose address is not held produces, on the next cycle, `rsp_valid_o` high with `rsp_hit_o` low. On the same cycle a downstream request appears with `dn_valid_o` high, opcode `dn_op_o` = 4'hB, and the lookup's address and program counter.
- R4: A local hit raises `hint_valid_o` on the response cycle with the hit's address and program counter. A miss leaves the hint low.
- R5: A header with `snp_op_i` = 4'h6 arms an install for `snp_addr_i`. The line then arrives as 4 payload beats of 128 bits, and beat k fills line bits [128k+127:128k]. After the fourth beat the line is held.
- R6: A lookup made before the final beat of a pending push misses that address.
- R7: A header with any opcode other than 4'h6 is accepted and does nothing. Beats that follow it install nothing.
- R8: While a push waits for its payload, `snp_ready_o` is low and a further header is held. `snp_ready_o` returns high on the cycle after the final beat.
- R9: The store holds 256 lines. An install of a new address into a full store evicts the entry that was installed earliest.
- R10: A push for an address already held overwrites that entry. It does not allocate a new one or change the eviction order.
- R11: A lookup on the same cycle as the final beat for the same address hits and returns the newly pushed line.
- R12: Payload beats that arrive while no push is pending are ignored. They do not shift the beat position of a later push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lk_valid_i | input | 1 | Lookup request from the cache controller |
| lk_addr_i | input | 26 | Line address of the lookup |
| lk_pc_i | input | 48 | Program counter of the lookup |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | Lookup was served locally |
| rsp_data_o | output | 512 | Line returned on a hit |
| dn_valid_o | output | 1 | Downstream read request valid |
| dn_op_o | output | 4 | Downstream opcode, read with program counter |
| dn_addr_o | output | 26 | Downstream line address |
| dn_pc_o | output | 48 | Downstream program counter |
| hint_valid_o | output | 1 | Local-hit report toward the device |
| hint_addr_o | output | 26 | Address of the reported hit |
| hint_pc_o | output | 48 | Program counter of the reported hit |
| snp_valid_i | input | 1 | Snoop header valid |
| snp_op_i | input | 4 | Snoop header opcode |
| snp_addr_i | input | 26 | Snoop header line address |
| snp_ready_o | output | 1 | Header can be accepted |
| pl_valid_i | input | 1 | Payload beat valid |
| pl_data_i | input | 128 | Payload beat data |

## Verification
The two functions that can fall in the same cycle are a cache-controller lookup and the completion of a device push. The bench provokes this by driving the final payload beat of a line that is not yet held and a lookup of that same address on one clock. It expects a hit carrying the pushed data and no downstream read. It also pauses a push after two beats and looks the address up, expecting a clean miss until the last beat lands.

// File: rtl/lpb_pkg.sv
package lpb_pkg;

    localparam int LPB_LINE_AW  = 26;
    localparam int LPB_PC_W     = 48;
    localparam int LPB_BEAT_W   = 128;
    localparam int LPB_LINE_W   = 512;
    localparam int LPB_BEATS    = LPB_LINE_W / LPB_BEAT_W;
    localparam int LPB_BCNT_W   = $clog2(LPB_BEATS);
    localparam int LPB_ENTRIES  = 256;
    localparam int LPB_OP_W     = 4;

    // header opcode that announces a pushed line
    localparam logic [LPB_OP_W-1:0] OP_PUSH_DATA = 4'h6;
    // downstream opcode: read carrying the program counter
    localparam logic [LPB_OP_W-1:0] OP_READ_PC   = 4'hB;

    typedef logic [LPB_LINE_AW-1:0] laddr_t;
    typedef logic [LPB_PC_W-1:0]    pc_t;
    typedef logic [LPB_LINE_W-1:0]  line_t;
    typedef logic [LPB_BEAT_W-1:0]  beat_t;

    typedef struct packed {
        logic   vld;
        laddr_t addr;
        line_t  data;
    } install_t;

    typedef enum logic {
        ARM_IDLE,
        ARM_WAIT
    } arm_state_e;

    function automatic line_t place_beat(line_t cur, beat_t beat, logic [LPB_BCNT_W-1:0] idx);
        line_t res;
        res = cur;
        res[int'(idx)*LPB_BEAT_W +: LPB_BEAT_W] = beat;
        return res;
    endfunction

endpackage

// File: rtl/lpb_tag_match.sv
module lpb_tag_match
    import lpb_pkg::*;
#(
    parameter int ENTRIES = LPB_ENTRIES,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [ENTRIES-1:0] valid_i,
    input  laddr_t             tags_i [ENTRIES],
    input  laddr_t             key_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);

    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_i[g] && (tags_i[g] == key_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) idx_o = idx_o | IDX_W'(i);
        end
    end

    assign hit_o = |match;

    // a line address is never held twice
    AST_TAG_UNIQUE: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(match)); // R10

endmodule

// File: rtl/lpb_push_arm.sv
module lpb_push_arm
    import lpb_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                snp_valid_i,
    input  logic [LPB_OP_W-1:0] snp_op_i,
    input  laddr_t              snp_addr_i,
    output logic                snp_ready_o,
    input  logic                pl_valid_i,
    input  beat_t               pl_data_i,
    output install_t            ins_o
);

    arm_state_e              state_q;
    laddr_t                  addr_q;
    logic [LPB_BCNT_W-1:0]   cnt_q;
    line_t                   acc_q;
    line_t                   acc_next;
    logic                    last_beat;

    assign snp_ready_o = (state_q == ARM_IDLE);

    always_comb begin
        acc_next   = place_beat(acc_q, pl_data_i, cnt_q);
        last_beat  = (state_q == ARM_WAIT) && pl_valid_i
                     && (cnt_q == LPB_BCNT_W'(LPB_BEATS - 1));
        ins_o.vld  = last_beat;
        ins_o.addr = addr_q;
        ins_o.data = acc_next;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ARM_IDLE;
            addr_q  <= '0;
            cnt_q   <= '0;
            acc_q   <= '0;
        end else begin
            case (state_q)
                ARM_IDLE: begin
                    if (snp_valid_i && snp_op_i == OP_PUSH_DATA) begin
                        state_q <= ARM_WAIT;
                        addr_q  <= snp_addr_i;
                        cnt_q   <= '0;
                        acc_q   <= '0;
                    end
                end
                ARM_WAIT: begin
                    if (pl_valid_i) begin
                        acc_q <= acc_next;
                        cnt_q <= cnt_q + 1'b1;
                        if (last_beat) state_q <= ARM_IDLE;
                    end
                end
                default: state_q <= ARM_IDLE;
            endcase
        end
    end

    AST_READY_AFTER_LAST: assert property (@(posedge clk_i) disable iff (rst_i)
        ins_o.vld |=> snp_ready_o); // R8

endmodule

// File: rtl/lpb_store.sv
module lpb_store
    import lpb_pkg::*;
#(
    parameter int ENTRIES = LPB_ENTRIES,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  install_t ins_i,
    input  laddr_t   lk_addr_i,
    output logic     lk_hit_o,
    output line_t    lk_data_o
);

    logic [ENTRIES-1:0] valid_q;
    laddr_t             tags_q [ENTRIES];
    line_t              data_q [ENTRIES];
    logic [IDX_W-1:0]   wr_ptr_q;
    logic [IDX_W-1:0]   lk_idx;
    logic               ins_hit;
    logic [IDX_W-1:0]   ins_idx;
    logic [IDX_W-1:0]   wr_idx;

    lpb_tag_match #(.ENTRIES(ENTRIES)) i_lk_match (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .valid_i (valid_q),
        .tags_i  (tags_q),
        .key_i   (lk_addr_i),
        .hit_o   (lk_hit_o),
        .idx_o   (lk_idx)
    );

    lpb_tag_match #(.ENTRIES(ENTRIES)) i_ins_match (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .valid_i (valid_q),
        .tags_i  (tags_q),
        .key_i   (ins_i.addr),
        .hit_o   (ins_hit),
        .idx_o   (ins_idx)
    );

    assign lk_data_o = data_q[lk_idx];
    assign wr_idx    = ins_hit ? ins_idx : wr_ptr_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_q  <= '0;
            wr_ptr_q <= '0;
        end else if (ins_i.vld) begin
            valid_q[wr_idx] <= 1'b1;
            if (!ins_hit) begin
                wr_ptr_q <= (wr_ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : wr_ptr_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (ins_i.vld) begin
            tags_q[wr_idx] <= ins_i.addr;
            data_q[wr_idx] <= ins_i.data;
        end
    end

endmodule

// File: rtl/lpb_landing_buf.sv
module lpb_landing_buf
    import lpb_pkg::*;
#(
    parameter int ENTRIES = LPB_ENTRIES
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   lk_valid_i,
    input  logic [LPB_LINE_AW-1:0] lk_addr_i,
    input  logic [LPB_PC_W-1:0]    lk_pc_i,
    output logic                   rsp_valid_o,
    output logic                   rsp_hit_o,
    output logic [LPB_LINE_W-1:0]  rsp_data_o,
    output logic                   dn_valid_o,
    output logic [LPB_OP_W-1:0]    dn_op_o,
    output logic [LPB_LINE_AW-1:0] dn_addr_o,
    output logic [LPB_PC_W-1:0]    dn_pc_o,
    output logic                   hint_valid_o,
    output logic [LPB_LINE_AW-1:0] hint_addr_o,
    output logic [LPB_PC_W-1:0]    hint_pc_o,
    input  logic                   snp_valid_i,
    input  logic [LPB_OP_W-1:0]    snp_op_i,
    input  logic [LPB_LINE_AW-1:0] snp_addr_i,
    output logic                   snp_ready_o,
    input  logic                   pl_valid_i,
    input  logic [LPB_BEAT_W-1:0]  pl_data_i
);

    install_t ins;
    logic     store_hit;
    line_t    store_data;
    logic     bypass;
    logic     hit_now;
    line_t    data_now;

    lpb_push_arm i_arm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .snp_valid_i (snp_valid_i),
        .snp_op_i    (snp_op_i),
        .snp_addr_i  (snp_addr_i),
        .snp_ready_o (snp_ready_o),
        .pl_valid_i  (pl_valid_i),
        .pl_data_i   (pl_data_i),
        .ins_o       (ins)
    );

    lpb_store #(.ENTRIES(ENTRIES)) i_store (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .ins_i     (ins),
        .lk_addr_i (lk_addr_i),
        .lk_hit_o  (store_hit),
        .lk_data_o (store_data)
    );

    always_comb begin
        bypass   = ins.vld && (ins.addr == lk_addr_i);
        hit_now  = bypass || store_hit;
        data_now = bypass ? ins.data : store_data;
    end

    assign dn_op_o = OP_READ_PC;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rsp_valid_o  <= 1'b0;
            rsp_hit_o    <= 1'b0;
            rsp_data_o   <= '0;
            dn_valid_o   <= 1'b0;
            dn_addr_o    <= '0;
            dn_pc_o      <= '0;
            hint_valid_o <= 1'b0;
            hint_addr_o  <= '0;
            hint_pc_o    <= '0;
        end else begin
            rsp_valid_o  <= lk_valid_i;
            rsp_hit_o    <= lk_valid_i && hit_now;
            rsp_data_o   <= (lk_valid_i && hit_now) ? data_now : '0;
            dn_valid_o   <= lk_valid_i && !hit_now;
            dn_addr_o    <= lk_addr_i;
            dn_pc_o      <= lk_pc_i;
            hint_valid_o <= lk_valid_i && hit_now;
            hint_addr_o  <= lk_addr_i;
            hint_pc_o    <= lk_pc_i;
        end
    end

    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
        lk_valid_i |=> rsp_valid_o); // R3

    AST_HIT_NO_FORWARD: assert property (@(posedge clk_i) disable iff (rst_i)
        (rsp_valid_o && rsp_hit_o) |-> !dn_valid_o); // R2

    AST_HINT_ONLY_ON_HIT: assert property (@(posedge clk_i) disable iff (rst_i)
        hint_valid_o |-> (rsp_valid_o && rsp_hit_o)); // R4

    AST_BYPASS_HITS: assert property (@(posedge clk_i) disable iff (rst_i)
        (lk_valid_i && ins.vld && ins.addr == lk_addr_i) |=> rsp_hit_o); // R11

endmodule

// File: tb/test_lpb_landing_buf.sv
module test_lpb_landing_buf;
    import lpb_pkg::*;

    logic   clk = 1'b0;
    logic   rst = 1'b1;
    logic   lk_valid = 1'b0;
    laddr_t lk_addr = '0;
    pc_t    lk_pc = '0;
    logic   rsp_valid, rsp_hit;
    line_t  rsp_data;
    logic   dn_valid;
    logic [LPB_OP_W-1:0] dn_op;
    laddr_t dn_addr, hint_addr;
    pc_t    dn_pc, hint_pc;
    logic   hint_valid;
    logic   snp_valid = 1'b0;
    logic [LPB_OP_W-1:0] snp_op = '0;
    laddr_t snp_addr = '0;
    logic   snp_ready;
    logic   pl_valid = 1'b0;
    beat_t  pl_data = '0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    line_t  mdl_data [laddr_t];
    laddr_t mdl_order [$];

    always #2 clk = ~clk;

    lpb_landing_buf i_lpb_landing_buf (
        .clk_i(clk), .rst_i(rst),
        .lk_valid_i(lk_valid), .lk_addr_i(lk_addr), .lk_pc_i(lk_pc),
        .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_data_o(rsp_data),
        .dn_valid_o(dn_valid), .dn_op_o(dn_op), .dn_addr_o(dn_addr), .dn_pc_o(dn_pc),
        .hint_valid_o(hint_valid), .hint_addr_o(hint_addr), .hint_pc_o(hint_pc),
        .snp_valid_i(snp_valid), .snp_op_i(snp_op), .snp_addr_i(snp_addr),
        .snp_ready_o(snp_ready),
        .pl_valid_i(pl_valid), .pl_data_i(pl_data)
    );

    task automatic chk(bit ok, string rq, string what, line_t act, line_t exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    function automatic void mdl_install(laddr_t a, line_t d);
        if (mdl_data.exists(a)) begin
            mdl_data[a] = d;
        end else begin
            if (mdl_order.size() == LPB_ENTRIES) begin
                laddr_t v = mdl_order.pop_front();
                mdl_data.delete(v);
            end
            mdl_order.push_back(a);
            mdl_data[a] = d;
        end
    endfunction

    function automatic line_t rnd_line();
        line_t l;
        for (int w = 0; w < LPB_LINE_W / 32; w++) l[w*32 +: 32] = $urandom;
        return l;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mdl_data.delete();
        mdl_order.delete();
    endtask

    // lookup with expectation taken from the model
    task automatic look(laddr_t a, pc_t pc, string rq);
        bit    eh = mdl_data.exists(a);
        line_t ed = eh ? mdl_data[a] : '0;
        bit    ok;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_pc = pc;
        @(negedge clk);
        lk_valid = 1'b0;
        ok = rsp_valid && (rsp_hit == eh) && (!eh || rsp_data == ed);
        chk(ok, rq, "hit/data", {rsp_hit, rsp_data[63:0]}, {eh, ed[63:0]});
        ok = (dn_valid == !eh) && (eh || (dn_op == 4'hB && dn_addr == a && dn_pc == pc));
        chk(ok, eh ? "R2" : "R3", "downstream", {dn_valid, dn_op, dn_addr}, {!eh, 4'hB, a});
        ok = (hint_valid == eh) && (!eh || (hint_addr == a && hint_pc == pc));
        chk(ok, "R4", "hint", {hint_valid, hint_addr, hint_pc}, {eh, a, pc});
    endtask

    task automatic send_hdr(logic [LPB_OP_W-1:0] op, laddr_t a);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_addr = a;
        while (!snp_ready) @(negedge clk);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // drive beats [first, first+cnt) of line d, ending on the negedge after the last
    task automatic send_beats(line_t d, int first, int cnt);
        for (int b = first; b < first + cnt; b++) begin
            pl_valid = 1'b1;
            pl_data = d[b*LPB_BEAT_W +: LPB_BEAT_W];
            @(negedge clk);
        end
        pl_valid = 1'b0;
    endtask

    task automatic push(laddr_t a, line_t d);
        send_hdr(OP_PUSH_DATA, a);
        send_beats(d, 0, LPB_BEATS);
        mdl_install(a, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL WDOG run act=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        line_t d0, d1, d2;
        void'($urandom(32'd1234));
        do_reset();

        // R1 reset state
        chk(!rsp_valid && !dn_valid && !hint_valid && snp_ready, "R1", "reset outputs",
            {rsp_valid, dn_valid, hint_valid, snp_ready}, 4'b0001);
        look(26'h10, 48'h1000, "R1");

        // R5 install and R2 hit, R3 miss elsewhere
        d0 = rnd_line();
        push(26'h20, d0);
        look(26'h20, 48'hAAA0, "R5");
        look(26'h21, 48'hAAA4, "R3");

        // R6 pause mid-payload
        d1 = rnd_line();
        send_hdr(OP_PUSH_DATA, 26'h30);
        send_beats(d1, 0, 2);
        look(26'h30, 48'hB000, "R6");
        @(negedge clk);
        send_beats(d1, 2, 2);
        mdl_install(26'h30, d1);
        look(26'h30, 48'hB004, "R5");

        // R7 foreign opcode then beats
        d2 = rnd_line();
        send_hdr(4'h3, 26'h40);
        chk(snp_ready, "R7", "ready after foreign header", {31'd0, snp_ready}, 1);
        @(negedge clk);
        send_beats(d2, 0, 4);
        look(26'h40, 48'hC000, "R7");

        // R12 stray beats, then a real push must land in order
        send_beats(rnd_line(), 0, 3);
        d2 = rnd_line();
        push(26'h50, d2);
        look(26'h50, 48'hC100, "R12");

        // R8 second header held while first is pending
        d0 = rnd_line();
        d1 = rnd_line();
        send_hdr(OP_PUSH_DATA, 26'h60);
        snp_valid = 1'b1; snp_op = OP_PUSH_DATA; snp_addr = 26'h61;
        @(negedge clk);
        chk(!snp_ready, "R8", "ready low while pending", {31'd0, snp_ready}, 0);
        @(negedge clk);
        chk(!snp_ready, "R8", "ready still low", {31'd0, snp_ready}, 0);
        send_beats(d0, 0, 4);
        chk(snp_ready, "R8", "ready back after last beat", {31'd0, snp_ready}, 1);
        @(negedge clk);
        snp_valid = 1'b0;
        send_beats(d1, 0, 4);
        mdl_install(26'h60, d0);
        mdl_install(26'h61, d1);
        look(26'h60, 48'hD000, "R8");
        look(26'h61, 48'hD004, "R8");

        // R11 same-cycle lookup and final beat
        d0 = rnd_line();
        send_hdr(OP_PUSH_DATA, 26'h70);
        send_beats(d0, 0, 3);
        pl_valid = 1'b1; pl_data = d0[3*LPB_BEAT_W +: LPB_BEAT_W];
        lk_valid = 1'b1; lk_addr = 26'h70; lk_pc = 48'hE000;
        @(negedge clk);
        pl_valid = 1'b0; lk_valid = 1'b0;
        chk(rsp_valid && rsp_hit && rsp_data == d0 && !dn_valid, "R11", "bypass hit",
            {rsp_hit, rsp_data[63:0]}, {1'b1, d0[63:0]});
        mdl_install(26'h70, d0);

        // R9 / R10 capacity, FIFO order and in-place overwrite
        do_reset();
        for (int i = 0; i < LPB_ENTRIES; i++) push(26'h100000 + 26'(i), rnd_line());
        look(26'h100000, 48'hF000, "R9");
        look(26'h1000FF, 48'hF004, "R9");
        push(26'h100005, rnd_line());
        look(26'h100005, 48'hF008, "R10");
        push(26'h200000, rnd_line());
        look(26'h100000, 48'hF00C, "R9");
        look(26'h100001, 48'hF010, "R10");
        look(26'h200000, 48'hF014, "R9");
        look(26'h100005, 48'hF018, "R10");

        // mixed random traffic on a small address pool
        for (int k = 0; k < 400; k++) begin
            int     r = $urandom_range(0, 2);
            laddr_t a = 26'h3000 + 26'($urandom_range(0, 40));
            if (r == 0) push(a, rnd_line());
            else look(a, pc_t'({$urandom, $urandom}), "R2");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule